// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers up to sixteen interrupt request lines from peripherals into a status register, and filters them through a mask register. It drives one pending line toward the CPU, which the CPU sees as a single bit of its exception cause state. A request line is edge sensitive: a low-to-high transition sets its status bit, and the bit then stays set until software acknowledges it. Line 3 is the one the DMA controller uses; it behaves like every other line.

Software reaches both registers over a simple register bus with 32-bit data. Only the low 16 bits carry meaning. Writes ignore the upper half, and reads return it as zero. To acknowledge a status bit, software writes 0 to it, because a status write ANDs the written value into the register. A mask write stores its value directly. After every cycle, including every write to either register, the pending line is recomputed from the new status and mask.

Top module: `irq_status_mask_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the status and mask registers read as zero and `cpu_irq_pend` is 0. `rst_n` is asynchronous and active low, and its release is synchronised through two flops.
- R2: A 0-to-1 transition of `irq_req[i]` between two clock edges sets status bit i at the next edge. A line held high sets the bit only once, so after an acknowledge the bit stays clear while the line stays high.
- R3: A write (`bus_en`=1, `bus_we`=1) to offset 0x1070 replaces the status with the old status AND `bus_wdata[15:0]`. Writing 1 keeps a bit and writing 0 clears it.
- R4: If a rising edge on line i arrives in the same cycle as a status write that clears bit i, the request wins and bit i is set after that edge.
- R5: A write to offset 0x1074 stores `bus_wdata[15:0]` into the mask register.
- R6: After every clock edge, `cpu_irq_pend` is 1 exactly when (status AND mask) is nonzero for the register values that edge produced.
- R7: A read (`bus_en`=1, `bus_we`=0) returns the addressed register combinationally in `bus_rdata[15:0]`, with `bus_rdata[31:16]` = 0. A read of any other offset, and any cycle that is not a read, gives `bus_rdata` = 0.
- R8: Writes to other offsets, cycles with `bus_en`=0, and `bus_wdata[31:16]` have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 16 | Peripheral request lines, rising-edge sensitive (bit 3 = DMA) |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register offset within the I/O window |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_rdata | output | 32 | Read data, zero-extended from 16 bits |
| cpu_irq_pend | output | 1 | Interrupt pending toward the CPU |

## Verification
A corrupted status bit shows up in the first status read that follows it. If the corresponding mask bit is set, it also shows on `cpu_irq_pend` one clock edge after the corruption. A wrong edge-detector history can make a held line set its bit again after an acknowledge, and the bench reads status in the very next cycles to catch this. A wrong mask value changes the pending line at the next edge, and a mask readback exposes it as well. The pending line is compared against the model after every edge, so a stale pending value is flagged within one cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_STAT = 2'd1,
    RSEL_MASK = 2'd2
  } rsel_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic prev_q;
    logic prev_d;

    always_comb begin
      prev_d = lvl[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= prev_d;
    end

    assign rise[i] = lvl[i] & ~prev_q;
  end
endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] STAT_OFS = 16'h1070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 16'h1074
) (
  input  logic [ADDR_W-1:0] addr,
  output rsel_e             sel
);
  always_comb begin
    if (addr == STAT_OFS)      sel = RSEL_STAT;
    else if (addr == MASK_OFS) sel = RSEL_MASK;
    else                       sel = RSEL_NONE;
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stat,
  input  logic         wr_mask,
  input  logic [N-1:0] wval,
  input  logic [N-1:0] rise,
  output logic [N-1:0] stat,
  output logic [N-1:0] mask,
  output logic         pend
);
  logic [N-1:0] stat_q, stat_d;
  logic [N-1:0] mask_q, mask_d;
  logic         pend_q, pend_d;
  logic [N-1:0] kept;

  always_comb begin
    kept   = wr_stat ? (stat_q & wval) : stat_q;
    stat_d = kept | rise;
    mask_d = wr_mask ? wval : mask_q;
    pend_d = |(stat_d & mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      pend_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (wr_mask) mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign stat = stat_q;
  assign mask = mask_q;
  assign pend = pend_q;
endmodule

// File: rtl/irq_status_mask_ctrl.sv
module irq_status_mask_ctrl
  import irqc_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                BUS_W    = 32,
  parameter int                N_LINES  = 16,
  parameter logic [ADDR_W-1:0] STAT_OFS = 16'h1070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 16'h1074
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_req,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               cpu_irq_pend
);
  localparam int PAD_W = BUS_W - N_LINES;

  logic               rst_sync_n;
  logic [N_LINES-1:0] rise;
  logic [N_LINES-1:0] stat_q;
  logic [N_LINES-1:0] mask_q;
  logic               wr_stat, wr_mask, rd_any;
  logic [N_LINES-1:0] rd_val;
  rsel_e              sel;
  logic               unused_hi;

  irqc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n)
  );

  irqc_edge #(.N(N_LINES)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .lvl(irq_req), .rise(rise)
  );

  irqc_decode #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  always_comb begin
    wr_stat = bus_en & bus_we & (sel == RSEL_STAT);
    wr_mask = bus_en & bus_we & (sel == RSEL_MASK);
    rd_any  = bus_en & ~bus_we;
    case (sel)
      RSEL_STAT: rd_val = stat_q;
      RSEL_MASK: rd_val = mask_q;
      default:   rd_val = '0;
    endcase
  end

  irqc_regs #(.N(N_LINES)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_stat(wr_stat), .wr_mask(wr_mask),
    .wval(bus_wdata[N_LINES-1:0]), .rise(rise),
    .stat(stat_q), .mask(mask_q), .pend(cpu_irq_pend)
  );

  assign bus_rdata = rd_any ? {{PAD_W{1'b0}}, rd_val} : '0;
  assign unused_hi = ^bus_wdata[BUS_W-1:N_LINES];
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int                ADDR_W   = 16,
  parameter int                BUS_W    = 32,
  parameter int                N        = 16,
  parameter logic [ADDR_W-1:0] STAT_OFS = 16'h1070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 16'h1074
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [N-1:0]      req,
  input logic              en,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wdata,
  input logic [BUS_W-1:0]  rdata,
  input logic [N-1:0]      stat,
  input logic [N-1:0]      mask,
  input logic              pend
);
  logic hit_stat, hit_mask;
  assign hit_stat = en & we & (addr == STAT_OFS);
  assign hit_mask = en & we & (addr == MASK_OFS);

  // R2: a status bit can only turn on while its request line is high
  a_r2_set_needs_req: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(req)) == '0));

  // R3: after an acknowledge, a bit survives only if written 1 or requested
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_ok)
    hit_stat |=> ((stat & ~$past(wdata[N-1:0]) & ~$past(req)) == '0));

  // R5: mask takes the low half of the written word
  a_r5_mask_store: assert property (@(posedge clk) disable iff (!rst_ok)
    hit_mask |=> (mask == $past(wdata[N-1:0])));

  // R8: mask holds without a write to its offset
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !hit_mask |=> $stable(mask));

  // R6: pending line tracks status AND mask
  a_r6_pend_match: assert property (@(posedge clk) disable iff (!rst_ok)
    pend == (|(stat & mask)));

  // R7: no read strobe means a zero read bus
  a_r7_rdata_idle: assert property (@(posedge clk) disable iff (!rst_ok)
    !(en && !we) |-> (rdata == '0));
endmodule

bind irq_status_mask_ctrl irqc_checker #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .N(N_LINES),
  .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .req(irq_req),
  .en(bus_en), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
  .rdata(bus_rdata), .stat(stat_q), .mask(mask_q), .pend(cpu_irq_pend)
);

// File: tb/tb_irq_status_mask_ctrl.sv
module tb_irq_status_mask_ctrl;
  localparam logic [15:0] STAT = 16'h1070;
  localparam logic [15:0] MASK = 16'h1074;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_req;
  logic        bus_en, bus_we;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        cpu_irq_pend;

  int errors = 0;
  int checks = 0;

  int m_stat = 0, m_mask = 0, m_prev = 0;
  bit m_pend = 1'b0;
  logic [15:0] cur_req = '0;

  always #2 clk = ~clk;

  irq_status_mask_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq_pend(cpu_irq_pend)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive, check read data, step model at the edge, check pending
  task automatic cyc(input logic en, input logic we, input logic [15:0] a,
                     input logic [31:0] wd, input logic [15:0] rq, input string tag);
    int exp_rd, rise, s;
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd; irq_req = rq;
    cur_req = rq;
    #1;
    exp_rd = 0;
    if (en && !we) exp_rd = (a == STAT) ? m_stat : (a == MASK) ? m_mask : 0;
    chk(bus_rdata == exp_rd, tag, bus_rdata, exp_rd);
    @(posedge clk);
    if (rst_n) begin
      rise = int'(rq) & ~m_prev & 32'hFFFF;
      s = m_stat;
      if (en && we && a == STAT) s = s & int'(wd[15:0]);
      s = s | rise;
      if (en && we && a == MASK) m_mask = int'(wd[15:0]);
      m_prev = int'(rq);
      m_stat = s;
      m_pend = (m_stat & m_mask) != 0;
    end
    @(negedge clk);
    chk(cpu_irq_pend == m_pend, {tag, "/R6"}, 32'(cpu_irq_pend), 32'(m_pend));
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, cur_req, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, cur_req, tag);
  endtask

  task automatic idle(input logic [15:0] rq, input string tag);
    cyc(1'b0, 1'b0, 16'h0, 32'h0, rq, tag);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    @(negedge clk);
    // R1: reset state (model stays zero while reset held)
    rd(STAT, "R1_stat_in_reset");
    rd(MASK, "R1_mask_in_reset");
    rst_n = 1'b1;
    repeat (3) idle(16'h0, "R1_release");
    rd(STAT, "R1_stat_after");
    rd(MASK, "R1_mask_after");

    // R2: rising edge on DMA line 3 sets bit 3; mask zero so no pending
    idle(16'h0008, "R2_dma_edge");
    rd(STAT, "R2_stat_bit3");
    // R5/R8: mask write with junk in upper half
    wr(MASK, 32'hABCD_0008, "R5_mask_write");
    rd(MASK, "R5_R8_mask_read");
    // R3: acknowledge bit 3 while line held high; R2 level does not re-set
    wr(STAT, 32'h0000_FFF7, "R3_ack_bit3");
    rd(STAT, "R2_held_no_reset");
    idle(16'h0008, "R2_held_idle");
    rd(STAT, "R2_held_stat");
    // R4: edge and acknowledge in the same cycle
    idle(16'h0000, "R4_drop");
    cyc(1'b1, 1'b1, STAT, 32'h0, 16'h0008, "R4_collision");
    rd(STAT, "R4_stat_kept");
    // R3: several bits, acknowledge keeps only bits written 1
    idle(16'h8429, "R2_multi_edge");
    rd(STAT, "R2_multi_stat");
    wr(STAT, 32'hFFFF_8001, "R3_partial_ack");
    rd(STAT, "R3_partial_stat");
    // R8: writes elsewhere or without enable do nothing
    wr(16'h1078, 32'h0, "R8_other_ofs");
    wr(16'h1072, 32'h0, "R8_half_ofs");
    cyc(1'b0, 1'b1, STAT, 32'h0, cur_req, "R8_no_enable");
    cyc(1'b0, 1'b1, MASK, 32'h0, cur_req, "R8_no_enable_mask");
    rd(STAT, "R8_stat_unchanged");
    rd(MASK, "R8_mask_unchanged");
    // R7: read of other offsets is zero
    rd(16'h1078, "R7_other_read");
    rd(16'h0000, "R7_zero_read");
    // R6: mask covering bit 15 raises pending, clearing mask drops it
    wr(MASK, 32'h0000_8000, "R6_mask_hi");
    rd(MASK, "R5_mask_hi");
    wr(MASK, 32'h0000_0000, "R6_mask_off");
    wr(STAT, 32'h0, "R3_clear_all");
    rd(STAT, "R3_all_clear");
    // R6: new edge on masked line raises pending
    wr(MASK, 32'h0000_0002, "R5_mask_bit1");
    idle(16'h0002, "R6_edge_line1");
    rd(STAT, "R2_line1_stat");
    wr(STAT, 32'h0000_FFFD, "R3_ack_line1");
    repeat (4) idle(16'h0000, "R6_quiet");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule